// File: doc/BRIEF.md
# Platform System Control Register File

This block is a byte-wide register file on a small I/O-port bus. It sits beside the processor on a workstation board. Software uses it to read fixed identification and equipment bytes and to set a handful of control bits. It also produces the side-effect signals that the rest of the board acts on:

- a processor reset level;
- a little-endian mode flag;
- a drive-activity indicator;
- an I/O map mode bit;
- two single-cycle strobes that toggle the lock of two NVRAM banks.

A two-byte scratch pair is also provided.

The bus has separate read and write enables, a 12-bit port address and an 8-bit data path. Writes take effect at the clock edge where `wr_en` is high, so state outputs and strobes change one cycle later. Reads are combinational: `rdata` shows the addressed byte in the same cycle that `rd_en` is high, and reads 0x00 when `rd_en` is low. Reads of ports that hold nothing return 0xFF. A write to a port that holds nothing raises a one-cycle error strobe.

Top module: `sysctl_regs`

## Requirements
- R1: After reset the following are all 0: `cpu_reset`, `little_endian`, `drive_led`, `io_map_sparse`, `nvlock1_pulse`, `nvlock2_pulse` and `bad_wr`. Reads of ports 0x81C, 0x850, 0x398 and 0x399 return 0x00.
- R2: A write to port 0x92 takes effect in the next cycle. Data bit 0 sets `cpu_reset` and data bit 1 sets `little_endian`, each to 1 or 0. A read of 0x92 returns 0x00.
- R3: Reads return these constants: 0x800 gives 0xEF, 0x802 gives 0xAD, 0x803 gives 0xE0, 0x80C gives 0x3C, 0x810 gives 0x39, 0x818 gives 0x00 and 0x823 gives 0x03.
- R4: Writes to 0x800, 0x802, 0x803 and 0x814 change no state and raise no `bad_wr`.
- R5: A write to 0x808 copies data bit 0 into `drive_led` in the next cycle.
- R6: A write to 0x810 raises `nvlock1_pulse`, and a write to 0x812 raises `nvlock2_pulse`. Each strobe is high for exactly the one cycle after the write.
- R7: A write to 0x81C stores data bits 3:0. A read of 0x81C returns those bits with bits 7:4 as zero.
- R8: A write to 0x850 stores data bit 0 as `io_map_sparse`. A read of 0x850 returns that bit in bit 0 and zeros above it.
- R9: Ports 0x398 and 0x399 are two independent 8-bit read/write bytes. A write to one leaves the other unchanged.
- R10: A read of 0x814, or of any port not listed in R2, R3, R5, R7, R8 and R9, returns 0xFF.
- R11: `rdata` reads 0x00 whenever `rd_en` is low.
- R12: A write to any port other than 0x92, 0x398, 0x399, 0x800, 0x802, 0x803, 0x808, 0x810, 0x812, 0x814, 0x81C and 0x850 raises `bad_wr` for the one following cycle and changes no state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Write strobe, one byte per cycle |
| rd_en | input | 1 | Read enable |
| addr | input | 12 | Port address |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data, combinational |
| cpu_reset | output | 1 | Processor reset level |
| little_endian | output | 1 | Little-endian mode flag |
| drive_led | output | 1 | Drive-activity indicator |
| io_map_sparse | output | 1 | I/O map mode bit |
| nvlock1_pulse | output | 1 | Lock-toggle strobe for NVRAM bank 1 |
| nvlock2_pulse | output | 1 | Lock-toggle strobe for NVRAM bank 2 |
| bad_wr | output | 1 | Strobe for a write to a port that holds nothing |

## Verification
The assertions assume that `addr` and `wdata` carry known values in every cycle where `wr_en` is high. They also assume at most one write per cycle, so at most one strobe can be active at a time. The bench meets both conditions by changing every input only on the falling clock edge and by issuing one access per task. Addresses and data are always driven to defined values before a strobe is raised.

// File: rtl/sysctl_regs.sv
module sysctl_regs #(
  parameter int AW    = 12,
  parameter int DW    = 8,
  parameter int CTL_W = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic          rd_en,
  input  logic [AW-1:0] addr,
  input  logic [DW-1:0] wdata,
  output logic [DW-1:0] rdata,
  output logic          cpu_reset,
  output logic          little_endian,
  output logic          drive_led,
  output logic          io_map_sparse,
  output logic          nvlock1_pulse,
  output logic          nvlock2_pulse,
  output logic          bad_wr
);
  localparam logic [AW-1:0] A_SPEC  = AW'('h092);
  localparam logic [AW-1:0] A_SCR0  = AW'('h398);
  localparam logic [AW-1:0] A_SCR1  = AW'('h399);
  localparam logic [AW-1:0] A_CPUID = AW'('h800);
  localparam logic [AW-1:0] A_FEAT  = AW'('h802);
  localparam logic [AW-1:0] A_STAT  = AW'('h803);
  localparam logic [AW-1:0] A_LED   = AW'('h808);
  localparam logic [AW-1:0] A_EQUIP = AW'('h80C);
  localparam logic [AW-1:0] A_LOCK1 = AW'('h810);
  localparam logic [AW-1:0] A_LOCK2 = AW'('h812);
  localparam logic [AW-1:0] A_INVAL = AW'('h814);
  localparam logic [AW-1:0] A_KEY   = AW'('h818);
  localparam logic [AW-1:0] A_CTL   = AW'('h81C);
  localparam logic [AW-1:0] A_CACHE = AW'('h823);
  localparam logic [AW-1:0] A_MAP   = AW'('h850);

  logic [CTL_W-1:0] ctl_q;
  logic [DW-1:0]    scr_q [2];
  logic             wr_known;
  logic [DW-1:0]    rd_mux;

  always_comb begin
    case (addr)
      A_SPEC, A_SCR0, A_SCR1, A_CPUID, A_FEAT, A_STAT, A_LED,
      A_LOCK1, A_LOCK2, A_INVAL, A_CTL, A_MAP: wr_known = 1'b1;
      default:                                 wr_known = 1'b0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cpu_reset     <= 1'b0;
      little_endian <= 1'b0;
      drive_led     <= 1'b0;
      io_map_sparse <= 1'b0;
      ctl_q         <= '0;
      nvlock1_pulse <= 1'b0;
      nvlock2_pulse <= 1'b0;
      bad_wr        <= 1'b0;
    end else begin
      nvlock1_pulse <= wr_en && (addr == A_LOCK1);
      nvlock2_pulse <= wr_en && (addr == A_LOCK2);
      bad_wr        <= wr_en && !wr_known;
      if (wr_en) begin
        case (addr)
          A_SPEC: begin
            cpu_reset     <= wdata[0];
            little_endian <= wdata[1];
          end
          A_LED:   drive_led     <= wdata[0];
          A_CTL:   ctl_q         <= wdata[CTL_W-1:0];
          A_MAP:   io_map_sparse <= wdata[0];
          default: ;
        endcase
      end
    end
  end

  for (genvar g = 0; g < 2; g++) begin : g_scr
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
        scr_q[g] <= '0;
      else if (wr_en && addr == A_SCR0 + AW'(g))
        scr_q[g] <= wdata;
    end
  end

  always_comb begin
    case (addr)
      A_SPEC:  rd_mux = '0;
      A_SCR0:  rd_mux = scr_q[0];
      A_SCR1:  rd_mux = scr_q[1];
      A_CPUID: rd_mux = DW'('hEF);
      A_FEAT:  rd_mux = DW'('hAD);
      A_STAT:  rd_mux = DW'('hE0);
      A_EQUIP: rd_mux = DW'('h3C);
      A_LOCK1: rd_mux = DW'('h39);
      A_KEY:   rd_mux = '0;
      A_CTL:   rd_mux = DW'(ctl_q);
      A_CACHE: rd_mux = DW'('h03);
      A_MAP:   rd_mux = DW'(io_map_sparse);
      default: rd_mux = '1;
    endcase
  end

  assign rdata = rd_en ? rd_mux : '0;
endmodule

// File: rtl/sysctl_regs_chk.sv
module sysctl_regs_chk #(
  parameter int AW = 12,
  parameter int DW = 8
) (
  input logic          clk,
  input logic          rst_n,
  input logic          wr_en,
  input logic          rd_en,
  input logic [AW-1:0] addr,
  input logic [DW-1:0] wdata,
  input logic [DW-1:0] rdata,
  input logic          cpu_reset,
  input logic          little_endian,
  input logic          drive_led,
  input logic          io_map_sparse,
  input logic          nvlock1_pulse,
  input logic          nvlock2_pulse,
  input logic          bad_wr
);
  p_spec_reset_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && addr == AW'('h092)) |=> (cpu_reset == $past(wdata[0])));
  p_spec_endian_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && addr == AW'('h092)) |=> (little_endian == $past(wdata[1])));
  p_spec_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en |=> ($stable(cpu_reset) && $stable(little_endian)));
  p_led_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && addr == AW'('h808)) |=> (drive_led == $past(wdata[0])));
  p_lock1_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && addr == AW'('h810)) |=> nvlock1_pulse);
  p_lock1_idle_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en |=> !nvlock1_pulse && !nvlock2_pulse);
  p_lock2_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && addr == AW'('h812)) |=> nvlock2_pulse);
  p_map_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en |=> $stable(io_map_sparse) && $stable(drive_led));
  p_idle_read_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_en |-> rdata == '0);
  p_one_strobe_r12: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({nvlock1_pulse, nvlock2_pulse, bad_wr}));
  p_known_no_err_r12: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && (addr == AW'('h800) || addr == AW'('h814))) |=> !bad_wr);
endmodule

bind sysctl_regs sysctl_regs_chk #(.AW(AW), .DW(DW)) i_chk (
  .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
  .wdata(wdata), .rdata(rdata), .cpu_reset(cpu_reset),
  .little_endian(little_endian), .drive_led(drive_led),
  .io_map_sparse(io_map_sparse), .nvlock1_pulse(nvlock1_pulse),
  .nvlock2_pulse(nvlock2_pulse), .bad_wr(bad_wr)
);

// File: tb/test_sysctl_regs.sv
module test_sysctl_regs;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic        rd_en = 1'b0;
  logic [11:0] addr = '0;
  logic [7:0]  wdata = '0;
  logic [7:0]  rdata;
  logic cpu_reset, little_endian, drive_led, io_map_sparse;
  logic nvlock1_pulse, nvlock2_pulse, bad_wr;
  int checks = 0;
  int errors = 0;

  always #10 clk = ~clk;

  sysctl_regs i_sysctl_regs (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
    .wdata(wdata), .rdata(rdata), .cpu_reset(cpu_reset),
    .little_endian(little_endian), .drive_led(drive_led),
    .io_map_sparse(io_map_sparse), .nvlock1_pulse(nvlock1_pulse),
    .nvlock2_pulse(nvlock2_pulse), .bad_wr(bad_wr)
  );

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %02h expected %02h", req, act, exp);
    end
  endtask

  // Leaves the caller at the falling edge after the write's clock edge.
  task automatic wr(input logic [11:0] a, input logic [7:0] d);
    @(negedge clk);
    wr_en = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic [11:0] a, output logic [7:0] d);
    rd_en = 1'b1; addr = a;
    #2 d = rdata;
    rd_en = 1'b0;
    #1;
  endtask

  task automatic rd_chk(input string req, input logic [11:0] a, input logic [7:0] exp);
    logic [7:0] v;
    rd(a, v);
    chk(req, v, exp);
  endtask

  task automatic t_reset;
    chk("R1 outputs", {cpu_reset, little_endian, drive_led, io_map_sparse,
                       nvlock1_pulse, nvlock2_pulse, bad_wr}, 8'h00);
    rd_chk("R1 ctl", 12'h81C, 8'h00);
    rd_chk("R1 map", 12'h850, 8'h00);
    rd_chk("R1 scr0", 12'h398, 8'h00);
    rd_chk("R1 scr1", 12'h399, 8'h00);
    #3 chk("R11 idle rdata", rdata, 8'h00);
  endtask

  task automatic t_special;
    wr(12'h092, 8'h01);
    chk("R2 reset set", {cpu_reset, little_endian}, 2'b10);
    wr(12'h092, 8'h02);
    chk("R2 endian set", {cpu_reset, little_endian}, 2'b01);
    wr(12'h092, 8'hFC);
    chk("R2 both clear", {cpu_reset, little_endian}, 2'b00);
    wr(12'h092, 8'h03);
    chk("R2 both set", {cpu_reset, little_endian}, 2'b11);
    rd_chk("R2 read", 12'h092, 8'h00);
  endtask

  task automatic t_ids;
    rd_chk("R3 800", 12'h800, 8'hEF);
    rd_chk("R3 802", 12'h802, 8'hAD);
    rd_chk("R3 803", 12'h803, 8'hE0);
    rd_chk("R3 80C", 12'h80C, 8'h3C);
    rd_chk("R3 810", 12'h810, 8'h39);
    rd_chk("R3 818", 12'h818, 8'h00);
    rd_chk("R3 823", 12'h823, 8'h03);
  endtask

  task automatic t_readonly;
    wr(12'h81C, 8'h05);
    wr(12'h800, 8'h12);
    chk("R4 no err 800", bad_wr, 1'b0);
    wr(12'h802, 8'h34);
    chk("R4 no err 802", bad_wr, 1'b0);
    wr(12'h803, 8'h56);
    wr(12'h814, 8'hFF);
    chk("R4 no err 814", bad_wr, 1'b0);
    rd_chk("R4 800 kept", 12'h800, 8'hEF);
    rd_chk("R4 802 kept", 12'h802, 8'hAD);
    rd_chk("R4 803 kept", 12'h803, 8'hE0);
    rd_chk("R4 ctl kept", 12'h81C, 8'h05);
  endtask

  task automatic t_led;
    wr(12'h808, 8'hFF);
    chk("R5 led on", drive_led, 1'b1);
    wr(12'h808, 8'hFE);
    chk("R5 led off", drive_led, 1'b0);
  endtask

  task automatic t_lock;
    wr(12'h810, 8'h00);
    chk("R6 lock1 pulse", {nvlock1_pulse, nvlock2_pulse}, 2'b10);
    @(negedge clk);
    chk("R6 lock1 end", {nvlock1_pulse, nvlock2_pulse}, 2'b00);
    wr(12'h812, 8'hA5);
    chk("R6 lock2 pulse", {nvlock1_pulse, nvlock2_pulse}, 2'b01);
    @(negedge clk);
    chk("R6 lock2 end", {nvlock1_pulse, nvlock2_pulse}, 2'b00);
  endtask

  task automatic t_ctl_map;
    wr(12'h81C, 8'hFA);
    rd_chk("R7 masked", 12'h81C, 8'h0A);
    wr(12'h81C, 8'h37);
    rd_chk("R7 second", 12'h81C, 8'h07);
    wr(12'h850, 8'hFF);
    chk("R8 map out", io_map_sparse, 1'b1);
    rd_chk("R8 map read", 12'h850, 8'h01);
    wr(12'h850, 8'hFE);
    rd_chk("R8 map clear", 12'h850, 8'h00);
  endtask

  task automatic t_scratch;
    wr(12'h398, 8'h5A);
    wr(12'h399, 8'hC3);
    rd_chk("R9 scr0", 12'h398, 8'h5A);
    rd_chk("R9 scr1", 12'h399, 8'hC3);
    wr(12'h398, 8'h81);
    rd_chk("R9 scr0 new", 12'h398, 8'h81);
    rd_chk("R9 scr1 kept", 12'h399, 8'hC3);
  endtask

  task automatic t_unmapped;
    rd_chk("R10 814", 12'h814, 8'hFF);
    rd_chk("R10 801", 12'h801, 8'hFF);
    rd_chk("R10 851", 12'h851, 8'hFF);
    rd_chk("R10 000", 12'h000, 8'hFF);
    #3 chk("R11 idle", rdata, 8'h00);
  endtask

  task automatic t_badwr;
    logic [7:0] before_ctl;
    rd(12'h81C, before_ctl);
    wr(12'h80C, 8'hFF);
    chk("R12 err 80C", bad_wr, 1'b1);
    @(negedge clk);
    chk("R12 err end", bad_wr, 1'b0);
    wr(12'h801, 8'h00);
    chk("R12 err 801", bad_wr, 1'b1);
    wr(12'h811, 8'hFF);
    chk("R12 no lock", {nvlock1_pulse, nvlock2_pulse, bad_wr}, 3'b001);
    rd_chk("R12 80C kept", 12'h80C, 8'h3C);
    rd_chk("R12 ctl kept", 12'h81C, before_ctl);
    wr(12'h398, 8'h00);
    chk("R12 scratch no err", bad_wr, 1'b0);
  endtask

  initial begin
    #20000000;
    errors++;
    $display("FAIL watchdog actual hung expected done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_special();
    t_ids();
    t_readonly();
    t_led();
    t_lock();
    t_ctl_map();
    t_scratch();
    t_unmapped();
    t_badwr();
    repeat (2) @(negedge clk);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule